// File: doc/BRIEF.md
# SD Card Block Read Receiver

This block takes in read data blocks sent by an SD card on its data lines, in either single-line or four-line mode. After a start pulse it captures its configuration and then waits on the card-clock tick for a block start bit. A programmable limit caps that wait. Once a block starts, the block packs the payload into bytes and emits each byte as a one-cycle pulse on a byte stream. It then checks a CRC16 on every active line.

The number of bytes per block and the number of blocks are programmable. The busy output acts as a self-clearing enable: it drops when every block has arrived, when a CRC mismatch ends the read, or when the start-bit wait runs out. A done flag, a CRC status bit and a timeout flag report how the read ended. All three stay valid until the next start pulse.

Top module: `sd_block_rx`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `tmo_o` and `out_valid_o` are 0 and `crc_ok_o` is 1.
- R2: A `start_i` pulse while idle sets `busy_o`, captures `wide_i`, `len_i`, `count_i` and `tmo_i`, and clears `done_o` and `tmo_o`. `busy_o` returns to 0 by itself when the read ends, and then exactly one of `done_o` or `tmo_o` is 1.
- R3: Each block carries `len_i`+1 bytes (field value 511 gives 512 bytes). A read delivers `count_i` blocks, so `count_i`*(`len_i`+1) bytes in total. A count of 0 is not a legal setting.
- R4: With `wide_i`=0, only `dat_i[0]` is used. A block starts on a tick where `dat_i[0]` is 0, and the bytes then arrive MSB first, one bit per tick.
- R5: With `wide_i`=1, a block starts on a tick where all four lines are 0. Each tick then carries one nibble: the upper nibble comes first, and `dat_i[3]` is the most significant bit of the nibble.
- R6: Each active line carries its own CRC16 (polynomial 0x1021, initial value 0) computed over that line's payload bits. The 16 CRC bits follow the payload on the same line, MSB first, and one end-bit tick follows them. After each block, `crc_ok_o` is 1 if every active line matched and 0 otherwise.
- R7: A CRC mismatch stops the read after the failing block. `done_o` is set, `busy_o` drops, and no later block is accepted.
- R8: While waiting for a start bit with a nonzero limit T, the T-th tick without a start bit sets `tmo_o` and clears `busy_o`, and `done_o` stays 0.
- R9: A limit of 0 turns the timeout off, so the block waits for a start bit indefinitely.
- R10: Data lines are sampled only in cycles where `tick_i` is 1. `out_valid_o` is a one-cycle pulse in the cycle after the tick that completes a byte.
- R11: A `start_i` pulse while `busy_o` is 1 has no effect. The configuration in use is not changed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a read when idle |
| tick_i | input | 1 | Card-clock sample strobe |
| dat_i | input | 4 | Data line samples, line 0 in bit 0 |
| wide_i | input | 1 | 0 = single line, 1 = four lines |
| len_i | input | LEN_W | Bytes per block minus one |
| count_i | input | CNT_W | Blocks per read |
| tmo_i | input | TMO_W | Start-bit wait limit in ticks, 0 = off |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | Read ended after its last block or after a CRC error |
| crc_ok_o | output | 1 | CRC result of the latest block |
| tmo_o | output | 1 | Start-bit wait expired |
| out_valid_o | output | 1 | Byte strobe |
| out_data_o | output | 8 | Received byte |

## Verification
The assertions assume a nonzero block count and assume nothing about how ticks are spaced. A byte always takes at least two ticks, so the strobe-spacing check holds even when a tick arrives every cycle. The stimulus raises a tick every other cycle and drives all-zero data lines in the cycles between ticks. Those lines would look like a start bit if the block sampled them. It changes configuration inputs only around start pulses, except for one deliberate change during a busy read.

// File: rtl/sd_block_rx.sv
module sd_block_rx #(
  parameter int          LEN_W = 11,
  parameter int          CNT_W = 8,
  parameter int          TMO_W = 24,
  parameter logic [15:0] POLY  = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [3:0]       dat_i,
  input  logic             wide_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             crc_ok_o,
  output logic             tmo_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o
);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_DATA, S_CRC, S_END} st_t;
  st_t st;

  logic             wide_q;
  logic [LEN_W-1:0] len_q, bytec;
  logic [CNT_W-1:0] cnt_q, blkc;
  logic [TMO_W-1:0] tmo_q, tcnt;
  logic [3:0]       bitc;
  logic [6:0]       sh;
  logic [3:0]       lane_ok;

  wire       sbit     = wide_q ? (dat_i == 4'h0) : !dat_i[0];
  wire       byte_end = wide_q ? (bitc == 4'd1) : (bitc == 4'd7);
  wire [7:0] sh_nx    = wide_q ? {sh[3:0], dat_i} : {sh, dat_i[0]};
  wire       crc_good = lane_ok[0] && (!wide_q || (&lane_ok[3:1]));
  wire       tmo_hit  = (tmo_q != '0) && ((tcnt + 1'b1) == tmo_q);
  wire       shifting = tick_i && (st == S_DATA || st == S_CRC);

  assign busy_o = (st != S_IDLE);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [15:0] crc;
    wire         fb = dat_i[l] ^ crc[15];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        crc <= '0;
      else if (st == S_IDLE || st == S_WAIT)
        crc <= '0;
      else if (shifting && (l == 0 || wide_q))
        crc <= {crc[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
    end
    assign lane_ok[l] = (crc == 16'h0000);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      wide_q      <= 1'b0;
      len_q       <= '0;
      cnt_q       <= '0;
      tmo_q       <= '0;
      bytec       <= '0;
      blkc        <= '0;
      tcnt        <= '0;
      bitc        <= '0;
      sh          <= '0;
      done_o      <= 1'b0;
      tmo_o       <= 1'b0;
      crc_ok_o    <= 1'b1;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      case (st)
        S_IDLE: if (start_i) begin
          wide_q <= wide_i;
          len_q  <= len_i;
          cnt_q  <= count_i;
          tmo_q  <= tmo_i;
          done_o <= 1'b0;
          tmo_o  <= 1'b0;
          tcnt   <= '0;
          blkc   <= '0;
          st     <= S_WAIT;
        end
        S_WAIT: if (tick_i) begin
          if (sbit) begin
            bitc  <= '0;
            bytec <= '0;
            tcnt  <= '0;
            st    <= S_DATA;
          end else if (tmo_hit) begin
            tmo_o <= 1'b1;
            st    <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_DATA: if (tick_i) begin
          sh <= sh_nx[6:0];
          if (byte_end) begin
            out_valid_o <= 1'b1;
            out_data_o  <= sh_nx;
            bitc        <= '0;
            if (bytec == len_q) st <= S_CRC;
            else bytec <= bytec + 1'b1;
          end else begin
            bitc <= bitc + 1'b1;
          end
        end
        S_CRC: if (tick_i) begin
          if (bitc == 4'd15) begin
            bitc <= '0;
            st   <= S_END;
          end else begin
            bitc <= bitc + 1'b1;
          end
        end
        S_END: if (tick_i) begin
          crc_ok_o <= crc_good;
          if (!crc_good || blkc == cnt_q - 1'b1) begin
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else begin
            blkc <= blkc + 1'b1;
            tcnt <= '0;
            st   <= S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_tmo_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |-> !busy_o);

  p_one_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (done_o ^ tmo_o));

  p_valid_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(tick_i));

  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |=> !out_valid_o);

endmodule

// File: tb/sd_block_rx_bench.sv
`timescale 1ns/1ps
module sd_block_rx_bench;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick = 1'b0, wide = 1'b0;
  logic [3:0]  dat = 4'hF;
  logic [10:0] len = '0;
  logic [7:0]  cnt = 8'd1;
  logic [23:0] tmo = '0;
  logic        busy, done, crc_ok, tmo_f, ov;
  logic [7:0]  od;
  int          checks = 0, fails = 0, ngot = 0;
  logic [7:0]  got [0:1023];

  sd_block_rx u_sd_block_rx (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick), .dat_i(dat),
    .wide_i(wide), .len_i(len), .count_i(cnt), .tmo_i(tmo),
    .busy_o(busy), .done_o(done), .crc_ok_o(crc_ok), .tmo_o(tmo_f),
    .out_valid_o(ov), .out_data_o(od));

  always #2.5 clk = ~clk;

  always @(negedge clk) if (rst_n && ov) begin
    if (ngot < 1024) got[ngot] = od;
    ngot++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int seed, input int k);
    return 8'((k * 29) + (seed * 7) + 3);
  endfunction

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((b ^ c[15]) ? 16'h1021 : 16'h0000);
  endfunction

  task automatic do_tick(input logic [3:0] d);
    @(negedge clk); dat = d; tick = 1'b1;
    @(negedge clk); tick = 1'b0; dat = 4'h0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic begin_xfer(input logic w, input int l, input int n, input int t);
    wide = w; len = 11'(l); cnt = 8'(n); tmo = 24'(t); ngot = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_block(input logic w, input int seed, input int base,
                            input int nbytes, input bit bad);
    logic [15:0] c [4];
    logic [7:0]  b;
    logic [3:0]  nib;
    for (int l = 0; l < 4; l++) c[l] = '0;
    do_tick(4'hF); do_tick(4'hF);
    do_tick(w ? 4'h0 : 4'hE);
    for (int k = 0; k < nbytes; k++) begin
      b = exp_byte(seed, base + k);
      if (w) begin
        for (int h = 0; h < 2; h++) begin
          nib = (h == 0) ? b[7:4] : b[3:0];
          for (int l = 0; l < 4; l++) c[l] = crc_step(c[l], nib[l]);
          do_tick(nib);
        end
      end else begin
        for (int i = 7; i >= 0; i--) begin
          c[0] = crc_step(c[0], b[i]);
          do_tick({3'b111, b[i]});
        end
      end
    end
    if (bad) c[0][0] = ~c[0][0];
    for (int i = 15; i >= 0; i--)
      do_tick(w ? {c[3][i], c[2][i], c[1][i], c[0][i]} : {3'b111, c[0][i]});
    do_tick(4'hF);
  endtask

  task automatic chk_bytes(input string tag, input int seed, input int n);
    chk({tag, " byte count"}, ngot, n);
    for (int k = 0; k < n; k++) chk({tag, " byte"}, got[k], exp_byte(seed, k));
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 tmo", tmo_f, 0);
    chk("R1 valid", ov, 0);  chk("R1 crc_ok", crc_ok, 1);
  endtask

  task automatic t_one_bit();
    begin_xfer(1'b0, 3, 1, 0);
    chk("R2 busy after start", busy, 1);
    send_block(1'b0, 1, 0, 4, 1'b0);
    settle();
    chk_bytes("R4 R10", 1, 4);
    chk("R2 done", done, 1); chk("R2 busy clears", busy, 0);
    chk("R6 crc ok 1-bit", crc_ok, 1); chk("R10 no stray valid", ov, 0);
  endtask

  task automatic t_four_bit_multi();
    begin_xfer(1'b1, 7, 2, 0);
    send_block(1'b1, 2, 0, 8, 1'b0);
    settle();
    chk("R3 busy between blocks", busy, 1); chk("R3 not done yet", done, 0);
    send_block(1'b1, 2, 8, 8, 1'b0);
    settle();
    chk_bytes("R5 R3", 2, 16);
    chk("R3 done", done, 1); chk("R6 crc ok 4-bit", crc_ok, 1);
  endtask

  task automatic t_crc_abort();
    begin_xfer(1'b1, 3, 3, 0);
    send_block(1'b1, 3, 0, 4, 1'b1);
    settle();
    chk("R6 crc fault", crc_ok, 0); chk("R7 done", done, 1); chk("R7 busy", busy, 0);
    chk("R7 bytes", ngot, 4);
    send_block(1'b1, 3, 4, 4, 1'b0);
    settle();
    chk("R7 later block ignored", ngot, 4); chk("R7 still idle", busy, 0);
  endtask

  task automatic t_timeout();
    begin_xfer(1'b0, 3, 1, 5);
    chk("R2 done cleared", done, 0);
    repeat (4) do_tick(4'hF);
    settle();
    chk("R8 still waiting", busy, 1); chk("R8 flag low", tmo_f, 0);
    do_tick(4'hF);
    settle();
    chk("R8 flag", tmo_f, 1); chk("R8 busy", busy, 0); chk("R8 done", done, 0);
  endtask

  task automatic t_no_timeout();
    begin_xfer(1'b1, 1, 1, 0);
    chk("R2 tmo cleared", tmo_f, 0);
    repeat (300) do_tick(4'hF);
    chk("R9 waits", busy, 1); chk("R9 no flag", tmo_f, 0);
    wide = 1'b0; len = 11'd9; cnt = 8'd4; tmo = 24'd2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    send_block(1'b1, 4, 0, 2, 1'b0);
    settle();
    chk_bytes("R11", 4, 2);
    chk("R11 done", done, 1); chk("R11 crc", crc_ok, 1);
  endtask

  task automatic t_max_len();
    begin_xfer(1'b1, 511, 1, 0);
    send_block(1'b1, 5, 0, 512, 1'b0);
    settle();
    chk_bytes("R3 max", 5, 512);
    chk("R3 max done", done, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one_bit();
    t_four_bit_multi();
    t_crc_abort();
    t_timeout();
    t_no_timeout();
    t_max_len();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule